// File: doc/BRIEF.md
# Word-Serial Burst Row Receiver

This block takes address events from a narrow shared bus on which row and column addresses travel one word at a time, and turns them into parallel row writes for a two-dimensional cell array. A burst opens with a single row word. One column word follows for every active cell in that row. Each column word is decoded into a one-hot bit as soon as it is accepted, and the bits build up into a column mask. The final column word carries a last flag. Once it is accepted, the row index and the whole mask are handed to a write stage, which presents them to the array as one parallel write.

The completed burst has its own holding slot, separate from the write stage. While one row write waits for the array to accept it, the next burst is already being decoded. The input is stalled only in one case: a finished burst is parked and the write stage still holds an unaccepted write. A column word that arrives with no burst open is discarded, and a one-cycle error pulse is raised. The default array size is 16 rows by 16 columns. Both the input word width and the row index width come from these sizes.

Top module: `brx_burst_rx`

## Requirements
- R1: While reset is applied, and on the first cycle after it, `wr_valid` and `err_pulse` are 0 and `in_ready` is 1.
- R2: An accepted word with `in_is_row`=1 opens a new burst. Its low row-index bits become the burst's row, and the column mask is cleared. `in_last` has no effect on a row word.
- R3: An accepted word with `in_is_row`=0 inside an open burst sets mask bit `i`, where `i` is the word's value (bit 0 is column 0). Repeating a column within the same burst leaves the mask unchanged.
- R4: An accepted column word with `in_last`=1 closes the burst. Exactly one write then appears on the output, carrying that burst's row and its accumulated mask.
- R5: Writes leave one at a time, in the order their bursts closed. While `wr_valid`=1 and `wr_ready`=0, `wr_valid`, `wr_row` and `wr_mask` hold their values.
- R6: A column word accepted while no burst is open is dropped. This happens after reset and after a burst has closed. `err_pulse` is 1 for exactly the one cycle after that word is accepted, and is 0 otherwise.
- R7: A row word accepted while a burst is still open abandons that burst. No write is issued for it, and its mask bits do not carry over.
- R8: `in_ready` goes to 0 only while a closed burst is parked and the output holds a write with `wr_ready`=0. A whole new burst can be accepted while the previous write is still outstanding.
- R9: Whenever `wr_valid`=1, `wr_mask` has at least one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Receiver can accept a word this cycle |
| in_is_row | input | 1 | 1 = row address word, 0 = column address word |
| in_last | input | 1 | Marks the final column word of a burst |
| in_word | input | max(log2 ROWS, log2 COLS) = 4 | Address carried by the word |
| wr_valid | output | 1 | A row write is presented |
| wr_ready | input | 1 | The array accepts the presented write |
| wr_row | output | log2 ROWS = 4 | Row index of the write |
| wr_mask | output | COLS = 16 | Column mask written to the row in parallel |
| err_pulse | output | 1 | One-cycle flag for a column word dropped outside a burst |

## Verification
The assertions assume two things about the input. First, once `in_valid` is raised, the word and its flags stay put until the handshake completes. Second, the array side only moves `wr_ready`, never the output data. The bench drives every word through a single task that holds it until `in_ready` is seen high. It changes `in_valid` and `wr_ready` only just after a rising edge, so both inputs are stable before the next edge samples them. The bench also never offers an address outside the configured array, so every decoded column and row index falls within range.

// File: rtl/brx_pkg.sv
package brx_pkg;
  // Kind of word carried on the shared address lines
  typedef enum logic {
    WK_COL = 1'b0,
    WK_ROW = 1'b1
  } word_kind_t;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/brx_col_decode.sv
module brx_col_decode #(
  parameter int COLS = 16,
  parameter int CAW  = 4
) (
  input  logic [CAW-1:0]  col_addr,
  output logic [COLS-1:0] col_onehot
);
  // One comparator per column; out-of-range codes decode to zero
  for (genvar gi = 0; gi < COLS; gi++) begin : g_bit
    assign col_onehot[gi] = (col_addr == CAW'(gi));
  end
endmodule

// File: rtl/brx_assemble.sv
module brx_assemble
  import brx_pkg::*;
#(
  parameter int COLS = 16,
  parameter int RAW  = 4,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc,
  input  word_kind_t      kind,
  input  logic            last,
  input  logic [AW-1:0]   word,
  input  logic [COLS-1:0] col_bit,
  input  logic            take,
  output logic            open_q,
  output logic            park_q,
  output logic [RAW-1:0]  row_q,
  output logic [COLS-1:0] mask_q,
  output logic            err_q
);
  logic            open_d, park_d, err_d;
  logic [RAW-1:0]  row_d;
  logic [COLS-1:0] mask_d;
  logic            row_en, mask_en;

  always_comb begin
    open_d  = open_q;
    park_d  = park_q & ~take;
    row_d   = word[RAW-1:0];
    mask_d  = mask_q;
    row_en  = 1'b0;
    mask_en = 1'b0;
    err_d   = 1'b0;
    if (acc) begin
      if (kind == WK_ROW) begin
        open_d  = 1'b1;
        row_en  = 1'b1;
        mask_d  = '0;
        mask_en = 1'b1;
      end else if (open_q) begin
        mask_d  = mask_q | col_bit;
        mask_en = 1'b1;
        if (last) begin
          open_d = 1'b0;
          park_d = 1'b1;
        end
      end else begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      park_q <= 1'b0;
      err_q  <= 1'b0;
      row_q  <= '0;
      mask_q <= '0;
    end else begin
      open_q <= open_d;
      park_q <= park_d;
      err_q  <= err_d;
      if (row_en)  row_q  <= row_d;
      if (mask_en) mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/brx_write_stage.sv
module brx_write_stage #(
  parameter int COLS = 16,
  parameter int RAW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [RAW-1:0]  row_in,
  input  logic [COLS-1:0] mask_in,
  input  logic            wr_ready,
  output logic            wr_valid,
  output logic [RAW-1:0]  wr_row,
  output logic [COLS-1:0] wr_mask,
  output logic            slot_free
);
  logic valid_d;

  always_comb begin
    slot_free = ~wr_valid | wr_ready;
    if (load)          valid_d = 1'b1;
    else if (wr_ready) valid_d = 1'b0;
    else               valid_d = wr_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_row   <= '0;
      wr_mask  <= '0;
    end else begin
      wr_valid <= valid_d;
      if (load) begin
        wr_row  <= row_in;
        wr_mask <= mask_in;
      end
    end
  end
endmodule

// File: rtl/brx_burst_rx.sv
module brx_burst_rx
  import brx_pkg::*;
#(
  parameter  int ROWS = 16,
  parameter  int COLS = 16,
  localparam int RAW  = $clog2(ROWS),
  localparam int CAW  = $clog2(COLS),
  localparam int AW   = int'(max_u(RAW, CAW))
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_is_row,
  input  logic            in_last,
  input  logic [AW-1:0]   in_word,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [RAW-1:0]  wr_row,
  output logic [COLS-1:0] wr_mask,
  output logic            err_pulse
);
  // Reset: asserted asynchronously, released after two clock edges
  logic rst_meta, rst_n_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_n_sync <= rst_meta;
    end
  end

  logic            acc, take, slot_free;
  logic            open_q, park_q;
  logic [RAW-1:0]  row_q;
  logic [COLS-1:0] mask_q, col_bit;
  word_kind_t      kind;

  assign kind     = in_is_row ? WK_ROW : WK_COL;
  assign take     = park_q & slot_free;
  assign in_ready = ~park_q | slot_free;
  assign acc      = in_valid & in_ready;

  brx_col_decode #(.COLS(COLS), .CAW(CAW)) u_dec (
    .col_addr   (in_word[CAW-1:0]),
    .col_onehot (col_bit)
  );

  brx_assemble #(.COLS(COLS), .RAW(RAW), .AW(AW)) u_asm (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .acc     (acc),
    .kind    (kind),
    .last    (in_last),
    .word    (in_word),
    .col_bit (col_bit),
    .take    (take),
    .open_q  (open_q),
    .park_q  (park_q),
    .row_q   (row_q),
    .mask_q  (mask_q),
    .err_q   (err_pulse)
  );

  brx_write_stage #(.COLS(COLS), .RAW(RAW)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .load      (take),
    .row_in    (row_q),
    .mask_in   (mask_q),
    .wr_ready  (wr_ready),
    .wr_valid  (wr_valid),
    .wr_row    (wr_row),
    .wr_mask   (wr_mask),
    .slot_free (slot_free)
  );

  logic unused_open;
  assign unused_open = open_q;
endmodule

// File: rtl/brx_checker.sv
module brx_checker #(
  parameter int COLS = 16,
  parameter int RAW  = 4
) (
  input logic            clk,
  input logic            rst_ok,
  input logic            in_valid,
  input logic            in_ready,
  input logic            in_is_row,
  input logic            wr_valid,
  input logic            wr_ready,
  input logic [RAW-1:0]  wr_row,
  input logic [COLS-1:0] wr_mask,
  input logic            err_pulse
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_ok |-> (!wr_valid && !err_pulse));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_row) && $stable(wr_mask)));

  p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    err_pulse |-> $past(in_valid && in_ready && !in_is_row));

  p_stall_only_busy_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_ready |-> (wr_valid && !wr_ready));

  p_mask_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    wr_valid |-> (wr_mask != '0));
endmodule

bind brx_burst_rx brx_checker #(.COLS(COLS), .RAW(RAW)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_n_sync),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_is_row (in_is_row),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_row    (wr_row),
  .wr_mask   (wr_mask),
  .err_pulse (err_pulse)
);

// File: tb/sim_brx_burst_rx.sv
`timescale 1ns/1ps
module sim_brx_burst_rx;
  localparam int ROWS = 16;
  localparam int COLS = 16;
  localparam int RW   = 4;
  localparam int AW   = 4;

  logic            clk;
  logic            rst_n;
  logic            in_valid, in_ready, in_is_row, in_last;
  logic [AW-1:0]   in_word;
  logic            wr_valid, wr_ready;
  logic [RW-1:0]   wr_row;
  logic [COLS-1:0] wr_mask;
  logic            err_pulse;

  int errors = 0;
  int checks = 0;
  int exp_err = 0;
  int seen_err = 0;
  int rdy_mode = 0;
  bit done = 0;
  logic [RW+COLS-1:0] exp_q[$];

  brx_burst_rx #(.ROWS(ROWS), .COLS(COLS)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_is_row(in_is_row),
    .in_last(in_last), .in_word(in_word),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_row(wr_row),
    .wr_mask(wr_mask), .err_pulse(err_pulse)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Ready pattern for the array side, changed just after each rising edge
  initial begin
    int cyc = 0;
    wr_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      cyc++;
      case (rdy_mode)
        0:       wr_ready = 1'b1;
        1:       wr_ready = 1'b0;
        default: wr_ready = (cyc % 3) != 0;
      endcase
    end
  end

  // Output monitor: order, content, stall rule, error pulses
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (err_pulse) seen_err++;
      if (!in_ready)
        check(wr_valid && !wr_ready, "R8 stall only when write busy", int'(in_ready), 1);
      if (wr_valid && wr_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected write", int'({wr_row, wr_mask}), 0);
        end else begin
          logic [RW+COLS-1:0] e;
          e = exp_q.pop_front();
          check({wr_row, wr_mask} == e, "R4/R5 write row+mask in order",
                int'({wr_row, wr_mask}), int'(e));
          check(wr_mask != '0, "R9 nonzero mask", int'(wr_mask), 1);
        end
      end
    end
  end

  task automatic send(input bit is_row, input bit last, input int w);
    bit got;
    in_valid  = 1'b1;
    in_is_row = is_row;
    in_last   = last;
    in_word   = AW'(w);
    got = 1'b0;
    while (!got) begin
      @(negedge clk);
      got = in_ready;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic burst(input int row, input logic [COLS-1:0] m);
    int hi;
    hi = 0;
    for (int c = 0; c < COLS; c++) if (m[c]) hi = c;
    exp_q.push_back({RW'(row), m});
    send(1'b1, 1'b0, row);
    for (int c = 0; c < COLS; c++)
      if (m[c]) send(1'b0, c == hi, c);
  endtask

  task automatic drain();
    int n;
    n = 0;
    while ((exp_q.size() != 0 || wr_valid) && n < 2000) begin
      @(posedge clk); #1;
      n++;
    end
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b0; in_is_row = 1'b0; in_last = 1'b0; in_word = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!wr_valid, "R1 reset wr_valid", int'(wr_valid), 0);
    check(!err_pulse, "R1 reset err_pulse", int'(err_pulse), 0);
    check(in_ready, "R1 reset in_ready", int'(in_ready), 1);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check(!wr_valid && in_ready, "R1 after release", int'({wr_valid, in_ready}), 1);

    // R6: column word before any row word is dropped
    exp_err++;
    send(1'b0, 1'b1, 3);
    @(negedge clk);
    check(err_pulse, "R6 error pulse after dropped column", int'(err_pulse), 1);
    @(negedge clk);
    check(!err_pulse, "R6 error pulse one cycle", int'(err_pulse), 0);
    @(posedge clk); #1;
    burst(5, 16'h0080);
    drain();

    // R3: single column per burst, every row and every column
    for (int c = 0; c < COLS; c++) burst(c, COLS'(1) << c);
    drain();

    // R3 R4 with a bursty array side: computed multi-bit masks
    rdy_mode = 2;
    for (int r = 0; r < ROWS; r++) begin
      logic [COLS-1:0] m;
      m = COLS'((r * 16'h03B5 + 16'h1111) ^ (r << 7));
      if (m == '0) m = 1;
      burst(r, m);
    end
    burst(15, 16'hFFFF);
    drain();
    rdy_mode = 0;

    // R3: repeated column in a burst is idempotent
    exp_q.push_back({RW'(6), 16'h0008});
    send(1'b1, 1'b0, 6);
    send(1'b0, 1'b0, 3);
    send(1'b0, 1'b0, 3);
    send(1'b0, 1'b1, 3);
    drain();

    // R7: a new row word abandons the open burst
    exp_q.push_back({RW'(4), 16'h0200});
    send(1'b1, 1'b0, 2);
    send(1'b0, 1'b0, 1);
    send(1'b1, 1'b0, 4);
    send(1'b0, 1'b1, 9);
    drain();

    // R2: last flag on a row word has no effect
    exp_q.push_back({RW'(9), 16'h0010});
    send(1'b1, 1'b1, 9);
    send(1'b0, 1'b1, 4);
    drain();

    // R6: column after a burst closed is dropped
    exp_err++;
    exp_q.push_back({RW'(1), 16'h0002});
    send(1'b1, 1'b0, 1);
    send(1'b0, 1'b1, 1);
    send(1'b0, 1'b1, 12);
    drain();

    // R8 R5: second burst decoded while first write is held
    rdy_mode = 1;
    @(posedge clk); #1;
    burst(1, 16'h00F0);
    burst(2, 16'h0101);
    @(negedge clk);
    check(!in_ready, "R8 stall with parked burst and busy output", int'(in_ready), 0);
    check(wr_valid && wr_row == 4'd1, "R5 first write held", int'(wr_row), 1);
    repeat (5) @(negedge clk);
    check(wr_valid && wr_row == 4'd1 && wr_mask == 16'h00F0, "R5 held stable",
          int'({wr_row, wr_mask}), int'({4'd1, 16'h00F0}));
    check(!in_ready, "R8 still stalled", int'(in_ready), 0);
    @(posedge clk); #1;
    rdy_mode = 0;
    drain();

    check(exp_q.size() == 0, "R4 all writes delivered", exp_q.size(), 0);
    check(seen_err == exp_err, "R6 error pulse count", seen_err, exp_err);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule